// File: doc/BRIEF.md
# Base-Page Effective Address Generator

This block produces the 16-bit memory address for every bus step of the short-address modes of an 8-bit processor. It does not use a fixed zero page. Short addresses land in a page chosen by a programmable base-page register, which the block holds internally. Software loads that register from the accumulator and can read it back. Reset clears it, so short addressing starts out in page zero.

The sequencer supplies the following each cycle:
- the addressing mode,
- the step within that mode,
- the 8-bit operand offset,
- the three index registers,
- the 16-bit stack pointer,
- the two pointer bytes already fetched from memory.

The address output is combinational from these inputs and the base-page register. It can therefore drive the address bus in the same cycle. Opcode decode and bus timing belong to the surrounding core.

The indirect modes take three steps. The first two fetch the low and high pointer bytes. The third is the final operand access.

Top module: `bpag_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the base-page register clears, and `b_out` reads 0 after that edge.
- R2: When `b_we` is high at a rising edge (reset inactive), `b_out` takes the value of `acc_in` after that edge. When `b_we` is low, `b_out` keeps its value.
- R3: Mode 0 (direct) gives `addr = {b_out, offset}` for every step value.
- R4: Mode 1 (indexed by X) and mode 2 (indexed by Y) give `addr = {b_out, (offset + index) mod 256}`. The sum never carries into the high byte, and the step has no effect.
- R5: Mode 3 (pre-indexed indirect with X) works as follows:
  - step 0 gives `{b_out, (offset + X) mod 256}`;
  - step 1 gives `{b_out, (offset + X + 1) mod 256}`;
  - the final step gives `{ptr_hi, ptr_lo}`, unindexed.
- R6: Mode 4 (post-indexed indirect with Y) and mode 5 (post-indexed indirect with Z) work as follows:
  - step 0 gives `{b_out, offset}`;
  - step 1 gives `{b_out, (offset + 1) mod 256}`;
  - the final step gives `({ptr_hi, ptr_lo} + index) mod 65536`, with carry into the high byte.
- R7: In mode 5, when Z is 0 the final address equals the unmodified pointer `{ptr_hi, ptr_lo}`. This is plain non-indexed indirect.
- R8: Mode 6 (stack-vector indirect with Y) works as follows:
  - step 0 gives `(sp + offset) mod 65536`;
  - step 1 gives `(sp + offset + 1) mod 65536`;
  - the final step gives `({ptr_hi, ptr_lo} + Y) mod 65536`.
- R9: Mode 7 is reserved and behaves exactly as mode 0.
- R10: Step encoding: 0 selects the low pointer byte fetch, 1 selects the high pointer byte fetch, and 2 or 3 select the final operand access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| b_we | input | 1 | Load base-page register from `acc_in` |
| acc_in | input | 8 | Accumulator value for the base-page load |
| b_out | output | 8 | Current base-page register value (read-back) |
| mode | input | 3 | Addressing mode code (0 to 7, see requirements) |
| step | input | 2 | Step within the mode (0, 1, 2/3) |
| offset | input | 8 | Operand offset byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| idx_z | input | 8 | Z index register |
| sp | input | 16 | Stack pointer |
| ptr_lo | input | 8 | Fetched pointer low byte |
| ptr_hi | input | 8 | Fetched pointer high byte |
| addr | output | 16 | Effective address for the current step |

## Verification
The base-page register is the only state in the block. If it is wrong, the error shows in the same cycle: every short-mode address and `b_out` carry a wrong high byte from the edge after the bad load or reset onward. Faults in the adders are a different matter. A wrong carry or a missing page wrap changes the output only for operands near a page edge, such as offset plus index crossing 0xFF or a pointer low byte overflowing. The bench therefore sweeps offsets and indices that include 0x00, 0x0F and 0xFF under several base pages, and compares every step of every mode.

// File: rtl/bpag_pkg.sv
// Package: shared mode and step codes for the base-page address generator.
// Assumes: the sequencer drives these codes directly; codes are fixed by the
// brief and must not be renumbered.
package bpag_pkg;

    typedef enum logic [2:0] {
        MODE_DIRECT = 3'd0,  // {B, d}
        MODE_DIR_X  = 3'd1,  // {B, d+X} wrapped in page
        MODE_DIR_Y  = 3'd2,  // {B, d+Y} wrapped in page
        MODE_IND_X  = 3'd3,  // pointer at {B, d+X}, unindexed
        MODE_IND_Y  = 3'd4,  // pointer at {B, d}, plus Y
        MODE_IND_Z  = 3'd5,  // pointer at {B, d}, plus Z
        MODE_SP_Y   = 3'd6,  // pointer at SP+d, plus Y
        MODE_RSVD   = 3'd7   // behaves as direct
    } mode_e;

    localparam logic [1:0] STEP_PTR_LO = 2'd0;
    localparam logic [1:0] STEP_PTR_HI = 2'd1;

endpackage

// File: rtl/bpag_base_reg.sv
// Module: base-page register.
// Holds the page used for short addressing. Loads from the accumulator on
// request, clears on synchronous active-low reset.
// Assumes: load and reset are sampled on the rising clock edge only.
module bpag_base_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // Register update: reset clears, load captures, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/bpag_page_sum.sv
// Module: in-page low-byte adder.
// Adds an offset, an index and a carry-in of one, keeping only W bits so the
// result wraps inside the page and never reaches the page byte.
// Assumes: caller zeroes the index when the mode is not indexed.
module bpag_page_sum #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inc,
    output logic [W-1:0] sum
);

    // Wrapped sum; carry out is discarded on purpose.
    always_comb begin
        sum = a + b + W'(inc);
    end

endmodule

// File: rtl/bpag_wide_add.sv
// Module: full-width address adder.
// Adds a zero-extended byte and a carry-in of one to a full address, with
// carry into the high part and wrap at the top of memory.
// Assumes: AW is wider than W.
module bpag_wide_add #(
    parameter int AW = 16,
    parameter int W  = 8
) (
    input  logic [AW-1:0] base,
    input  logic [W-1:0]  addend,
    input  logic          inc,
    output logic [AW-1:0] sum
);

    // Full carry-propagating sum, wrapping modulo 2**AW.
    always_comb begin
        sum = base + AW'(addend) + AW'(inc);
    end

endmodule

// File: rtl/bpag_unit.sv
// Module: base-page effective address generator (top).
// Forms the address for each step of the short-address modes: direct,
// page-indexed, pre-indexed indirect (X), post-indexed indirect (Y, Z) and
// stack-vector indirect (Y). The page byte comes from an internal base-page
// register loaded from the accumulator.
// Assumes: mode/step/operands are stable for the cycle; address output is
// combinational so it can drive the bus in the same cycle.
module bpag_unit #(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            b_we,
    input  logic [W-1:0]    acc_in,
    output logic [W-1:0]    b_out,
    input  logic [2:0]      mode,
    input  logic [1:0]      step,
    input  logic [W-1:0]    offset,
    input  logic [W-1:0]    idx_x,
    input  logic [W-1:0]    idx_y,
    input  logic [W-1:0]    idx_z,
    input  logic [2*W-1:0]  sp,
    input  logic [W-1:0]    ptr_lo,
    input  logic [W-1:0]    ptr_hi,
    output logic [2*W-1:0]  addr
);
    import bpag_pkg::*;

    localparam int AW = 2 * W;

    mode_e         m;
    logic          is_final;
    logic          is_second;
    logic [W-1:0]  idx_sel;
    logic [W-1:0]  page_idx;
    logic          page_inc;
    logic [W-1:0]  ptr_idx;
    logic [W-1:0]  page_lo;
    logic [AW-1:0] sp_addr;
    logic [AW-1:0] ptr_addr;
    logic [W-1:0]  page_q;

    bpag_base_reg #(.W(W)) u_breg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (b_we),
        .din   (acc_in),
        .q     (page_q)
    );

    assign b_out = page_q;

    // Decode mode code and step phase.
    always_comb begin
        m         = mode_e'(mode);
        is_final  = step[1];
        is_second = (step == STEP_PTR_HI);
    end

    // Pick the index register the mode names.
    always_comb begin
        case (m)
            MODE_DIR_X, MODE_IND_X:            idx_sel = idx_x;
            MODE_DIR_Y, MODE_IND_Y, MODE_SP_Y: idx_sel = idx_y;
            MODE_IND_Z:                        idx_sel = idx_z;
            default:                           idx_sel = '0;
        endcase
    end

    // Route the index to the in-page adder or to the pointer adder.
    always_comb begin
        page_idx = (m inside {MODE_DIR_X, MODE_DIR_Y, MODE_IND_X}) ? idx_sel : '0;
        page_inc = is_second && (m inside {MODE_IND_X, MODE_IND_Y, MODE_IND_Z});
        ptr_idx  = (m inside {MODE_IND_Y, MODE_IND_Z, MODE_SP_Y}) ? idx_sel : '0;
    end

    bpag_page_sum #(.W(W)) u_page (
        .a   (offset),
        .b   (page_idx),
        .inc (page_inc),
        .sum (page_lo)
    );

    bpag_wide_add #(.AW(AW), .W(W)) u_spadd (
        .base   (sp),
        .addend (offset),
        .inc    (is_second),
        .sum    (sp_addr)
    );

    bpag_wide_add #(.AW(AW), .W(W)) u_ptradd (
        .base   ({ptr_hi, ptr_lo}),
        .addend (ptr_idx),
        .inc    (1'b0),
        .sum    (ptr_addr)
    );

    // Select the address for this mode and step.
    always_comb begin
        case (m)
            MODE_IND_X, MODE_IND_Y, MODE_IND_Z:
                addr = is_final ? ptr_addr : {page_q, page_lo};
            MODE_SP_Y:
                addr = is_final ? ptr_addr : sp_addr;
            default:
                addr = {page_q, page_lo};
        endcase
    end

endmodule

// File: rtl/bpag_unit_chk.sv
// Checker: temporal properties of the base-page address generator, bound to
// the top module. Observes ports only.
module bpag_unit_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           b_we,
    input logic [W-1:0]   acc_in,
    input logic [W-1:0]   b_out,
    input logic [2:0]     mode,
    input logic [1:0]     step,
    input logic [W-1:0]   offset,
    input logic [W-1:0]   idx_x,
    input logic [W-1:0]   idx_y,
    input logic [W-1:0]   idx_z,
    input logic [2*W-1:0] sp,
    input logic [W-1:0]   ptr_lo,
    input logic [W-1:0]   ptr_hi,
    input logic [2*W-1:0] addr
);
    localparam int AW = 2 * W;

    // R1: reset clears the page register.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0));

    // R2: load takes the accumulator value.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |=> (b_out == $past(acc_in)));

    // R2: no load, no change.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !b_we |=> $stable(b_out));

    // R4: short direct and page-indexed modes stay in the base page.
    a_r4_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mode inside {3'd0, 3'd1, 3'd2, 3'd7}) |-> (addr[AW-1:W] == b_out));

    // R5: final step of pre-indexed indirect uses the pointer unindexed.
    a_r5_ptr_final: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && step[1]) |-> (addr == {ptr_hi, ptr_lo}));

    // R6: second pointer byte of post-indexed modes is the next in-page byte.
    a_r6_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd4 || mode == 3'd5) && step == 2'd1)
        |-> (addr == {b_out, W'(offset + W'(1))}));

    // R8: first stack-vector fetch is stack pointer plus offset.
    a_r8_sp_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && step == 2'd0) |-> (addr == AW'(sp + AW'(offset))));

    // R7: zero Z leaves the pointer unmodified.
    a_r7_zero_z: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && step[1] && idx_z == '0) |-> (addr == {ptr_hi, ptr_lo}));

endmodule

bind bpag_unit bpag_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .b_we   (b_we),
    .acc_in (acc_in),
    .b_out  (b_out),
    .mode   (mode),
    .step   (step),
    .offset (offset),
    .idx_x  (idx_x),
    .idx_y  (idx_y),
    .idx_z  (idx_z),
    .sp     (sp),
    .ptr_lo (ptr_lo),
    .ptr_hi (ptr_hi),
    .addr   (addr)
);

// File: tb/bpag_unit_test.sv
// Bench: sweeps modes, steps, offsets, indices and base pages, comparing the
// address against arithmetic computed here from the requirements.
module bpag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_we = 1'b0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  b_out;
    logic [2:0]  mode = '0;
    logic [1:0]  step = '0;
    logic [7:0]  offset = '0;
    logic [7:0]  idx_x = '0, idx_y = '0, idx_z = '0;
    logic [15:0] sp = '0;
    logic [7:0]  ptr_lo = '0, ptr_hi = '0;
    logic [15:0] addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bpag_unit uut (
        .clk(clk), .rst_n(rst_n), .b_we(b_we), .acc_in(acc_in), .b_out(b_out),
        .mode(mode), .step(step), .offset(offset), .idx_x(idx_x), .idx_y(idx_y),
        .idx_z(idx_z), .sp(sp), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .addr(addr)
    );

    function automatic int ref_addr(int m, int s, int b, int d, int x, int y,
                                    int z, int spv, int pl, int ph);
        int fin = (s >= 2) ? 1 : 0;   // R10: steps 2 and 3 are final
        int sec = (s == 1) ? 1 : 0;
        int ptr = ph * 256 + pl;
        case (m)
            1: return b * 256 + ((d + x) % 256);
            2: return b * 256 + ((d + y) % 256);
            3: return fin ? ptr : b * 256 + ((d + x + sec) % 256);
            4: return fin ? (ptr + y) % 65536 : b * 256 + ((d + sec) % 256);
            5: return fin ? (ptr + z) % 65536 : b * 256 + ((d + sec) % 256);
            6: return fin ? (ptr + y) % 65536 : (spv + d + sec) % 65536;
            default: return b * 256 + d;  // modes 0 and 7
        endcase
    endfunction

    function automatic string tag_of(int m, int z, int s);
        case (m)
            0: return "R3";
            1, 2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return (z == 0 && s >= 2) ? "R7" : "R6";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_b(input string tag, input logic [7:0] exp);
        n_vec++;
        if (b_out !== exp) begin
            n_bad++;
            $display("FAIL %s b_out actual %h expected %h", tag, b_out, exp);
        end
    endtask

    task automatic load_b(input logic [7:0] v);
        @(negedge clk);
        acc_in = v;
        b_we = 1'b1;
        @(negedge clk);
        b_we = 1'b0;
        check_b("R2 load", v);
        acc_in = ~v;
        @(negedge clk);
        check_b("R2 hold", v);
    endtask

    initial begin
        logic [7:0] bvals [3];
        bvals[0] = 8'h00; bvals[1] = 8'h3C; bvals[2] = 8'hFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_b("R1 reset", 8'h00);
        for (int bi = 0; bi < 3; bi++) begin
            load_b(bvals[bi]);
            for (int di = 0; di < 18; di++) begin
                for (int ii = 0; ii < 18; ii++) begin
                    for (int m = 0; m < 8; m++) begin
                        for (int s = 0; s < 4; s++) begin
                            int d = di * 15;
                            int ix = ii * 15;
                            int exp;
                            offset = 8'(d);
                            idx_x  = 8'(ix);
                            idx_y  = 8'(ix ^ 8'h5A);
                            idx_z  = 8'(ix);
                            sp     = {8'(ix), 8'(d ^ 8'hF0)};
                            ptr_lo = 8'(d ^ ix);
                            ptr_hi = 8'(d + ix);
                            mode   = 3'(m);
                            step   = 2'(s);
                            #1;
                            exp = ref_addr(m, s, bvals[bi], d, ix, ix ^ 8'h5A, ix,
                                           int'(sp), int'(ptr_lo), int'(ptr_hi));
                            n_vec++;
                            if (addr !== 16'(exp)) begin
                                n_bad++;
                                $display("FAIL %s mode %0d step %0d actual %h expected %h",
                                         tag_of(m, ix, s), m, s, addr, 16'(exp));
                            end
                        end
                    end
                end
            end
        end
        // R1: reset clears a nonzero page.
        load_b(8'hA7);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_b("R1 reclear", 8'h00);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                n_bad++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule